// File: doc/BRIEF.md
# Saturating Configurable Barrel Shifter

This block shifts a 32-bit data word by an arbitrary amount in a single clock. Three shift kinds are offered, logical left, logical right and arithmetic right, plus a pass-through code. The shift amount arrives on a full 32-bit unsigned count input, and a mode bit decides how that count is read.

In wrap mode the block behaves like a typical processor shifter. Only the low five count bits are used, so a count of 32 is the same as a count of 0. In saturating mode any count of 32 or more gives the mathematically correct result. That is zero for logical shifts, and copies of the sign bit for an arithmetic right shift.

The shifting itself is one right-shift core of five logarithmic multiplexer stages. Left shifts are formed by reversing the bit order before and after the core. The result is registered and qualified by an output valid strobe one cycle after the input strobe.

Top module: `sat_barrel_shifter`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. A synchronous active-high `rst` clears `out_valid` and `out_result` to zero.
- R2: `in_op` selects the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 pass-through. Pass-through registers `in_data` unchanged for any count and mode.
- R3: With `in_sat`=0 (wrap), only `in_count[4:0]` is used and bits 31:5 have no effect. A count of 32 therefore gives the unshifted data.
- R4: With `in_sat`=1, a logical left or logical right shift by a count of 32 or more yields 32'h0.
- R5: With `in_sat`=1, an arithmetic right shift by a count of 32 or more yields all ones for negative data and all zeros for non-negative data.
- R6: With `in_sat`=1 and a count below 32, the result equals the plain shift by that count.
- R7: The count is unsigned. 32'hFFFFFFFF and 32'h7FFFFFFF are out of range and saturate in saturating mode.
- R8: While `in_valid` is low, `out_result` keeps its previous value, whatever the other inputs do.
- R9: An in-range arithmetic right shift fills vacated upper bits with copies of `in_data[31]`. Logical shifts fill with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands valid this cycle |
| in_data | input | 32 | Word to shift |
| in_count | input | 32 | Unsigned shift amount |
| in_op | input | 2 | Operation select (see R2) |
| in_sat | input | 1 | 0 wrap mode, 1 saturating mode |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Registered shift result |

## Verification
The bench targets the count values on either side of the word width: 0, 31, 32, 33, 32'h7FFFFFFF and 32'hFFFFFFFF. Each is applied under both modes, all four operations, and both signs of data. A design that ignored the mode would return unshifted data for a saturated count of 32. A design that checked only bit 5 of the count would let 32'h7FFFFFC0-style counts through as small shifts. A design that sign-filled logical shifts, or zero-filled a saturated arithmetic shift of negative data, would give a wrong upper word. Separate checks cover pass-through under extreme counts, result hold while idle, and the reset state.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        OP_SHL  = 2'b00,
        OP_SHR  = 2'b01,
        OP_SAR  = 2'b10,
        OP_PASS = 2'b11
    } shift_op_e;
endpackage

// File: rtl/sbs_count_decode.sv
module sbs_count_decode #(
    parameter int CNT_W = 32,
    parameter int AMT_W = 5
) (
    input  logic [CNT_W-1:0] count,
    input  logic             sat_mode,
    output logic [AMT_W-1:0] amount,
    output logic             saturate
);
    // Low bits always drive the core; upper bits only matter when saturating.
    assign amount = count[AMT_W-1:0];

    generate
        if (CNT_W > AMT_W) begin : g_upper
            assign saturate = sat_mode & (|count[CNT_W-1:AMT_W]);
        end else begin : g_none
            assign saturate = sat_mode & 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sbs_right_core.sv
module sbs_right_core #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic             fill,
    input  logic [AMT_W-1:0] amount,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stage [AMT_W+1];

    assign stage[0] = din;

    // Stage s shifts right by 2**s when amount[s] is set.
    generate
        for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = amount[s] ? {{STEP{fill}}, stage[s][W-1:STEP]}
                                          : stage[s];
        end
    endgenerate

    assign dout = stage[AMT_W];
endmodule

// File: rtl/sbs_bit_reverse.sv
module sbs_bit_reverse #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign dout[i] = din[W-1-i];
        end
    endgenerate
endmodule

// File: rtl/sat_barrel_shifter.sv
module sat_barrel_shifter
    import sbs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_count,
    input  logic [1:0]        in_op,
    input  logic              in_sat,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int AMT_W = $clog2(DATA_W);

    shift_op_e         op;
    logic [AMT_W-1:0]  amount;
    logic              saturate;
    logic              sign_bit;
    logic              core_fill;
    logic [DATA_W-1:0] data_rev;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] core_out_rev;
    logic [DATA_W-1:0] next_result;

    assign op       = shift_op_e'(in_op);
    assign sign_bit = in_data[DATA_W-1];

    sbs_count_decode #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_decode (
        .count    (in_count),
        .sat_mode (in_sat),
        .amount   (amount),
        .saturate (saturate)
    );

    sbs_bit_reverse #(.W(DATA_W)) u_rev_in (
        .din  (in_data),
        .dout (data_rev)
    );

    // A left shift is a right shift of the bit-reversed word.
    assign core_in   = (op == OP_SHL) ? data_rev : in_data;
    assign core_fill = (op == OP_SAR) & sign_bit;

    sbs_right_core #(.W(DATA_W), .AMT_W(AMT_W)) u_core (
        .din    (core_in),
        .fill   (core_fill),
        .amount (amount),
        .dout   (core_out)
    );

    sbs_bit_reverse #(.W(DATA_W)) u_rev_out (
        .din  (core_out),
        .dout (core_out_rev)
    );

    always_comb begin
        unique case (op)
            OP_SHL:  next_result = saturate ? '0 : core_out_rev;
            OP_SHR:  next_result = saturate ? '0 : core_out;
            OP_SAR:  next_result = saturate ? {DATA_W{sign_bit}} : core_out;
            OP_PASS: next_result = in_data;
            default: next_result = in_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= next_result;
            end
        end
    end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [CNT_W-1:0]  in_count,
    input logic [1:0]        in_op,
    input logic              in_sat,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    localparam int AMT_W = $clog2(DATA_W);

    logic big_count;
    assign big_count = |in_count[CNT_W-1:AMT_W];

    a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b11) |=> out_result == $past(in_data));

    a_r3_wrap_zero_amount: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sat && in_count[AMT_W-1:0] == '0)
        |=> out_result == $past(in_data));

    a_r4_sat_logical_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sat && big_count && (in_op == 2'b00 || in_op == 2'b01))
        |=> out_result == '0);

    a_r5_sat_arith_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sat && big_count && in_op == 2'b10)
        |=> out_result == {DATA_W{$past(in_data[DATA_W-1])}});

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
endmodule

bind sat_barrel_shifter sbs_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sbs_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_count   (in_count),
    .in_op      (in_op),
    .in_sat     (in_sat),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/sat_barrel_shifter_bench.sv
module sat_barrel_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [31:0] in_count = '0;
    logic [1:0]  in_op = 2'b00;
    logic        in_sat = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_barrel_shifter u_sat_barrel_shifter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_count(in_count), .in_op(in_op), .in_sat(in_sat),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from the requirements, using language shift operators.
    function automatic logic [31:0] model(logic [31:0] d, logic [31:0] c,
                                          logic [1:0] op, logic sat);
        logic [31:0] amt;
        if (op == 2'b11) return d;
        amt = sat ? c : {27'd0, c[4:0]};
        if (amt >= 32) return (op == 2'b10) ? {32{d[31]}} : 32'h0;
        case (op)
            2'b00:   return d << amt;
            2'b01:   return d >> amt;
            default: return 32'($signed(d) >>> amt);
        endcase
    endfunction

    function automatic string tag_of(logic [31:0] c, logic [1:0] op, logic sat);
        if (op == 2'b11) return "R2";
        if (!sat) return "R3";
        if (c >= 32 && c[31]) return "R7";
        if (c >= 32) return (op == 2'b10) ? "R5" : "R4";
        return (op == 2'b10) ? "R9" : "R6";
    endfunction

    // Drive one operation at a falling edge, sample after the next rising edge.
    task automatic apply(logic [31:0] d, logic [31:0] c, logic [1:0] op, logic sat);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_count = c; in_op = op; in_sat = sat;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_one(string req, logic [31:0] d, logic [31:0] c,
                           logic [1:0] op, logic sat, logic [31:0] exp);
        apply(d, c, op, sat);
        check(req, out_result, exp);
    endtask

    task automatic t_reset();
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF; in_count = 32'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset result", out_result, 32'h0);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_valid();
        apply(32'h1, 32'd1, 2'b00, 1'b0);
        check("R1 valid high", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R1 valid low", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_directed();
        run_one("R2 shl 31", 32'h0000_0001, 32'd31, 2'b00, 1'b0, 32'h8000_0000);
        run_one("R2 shr 31", 32'h8000_0000, 32'd31, 2'b01, 1'b0, 32'h0000_0001);
        run_one("R2 pass", 32'h1234_5678, 32'hFFFF_FFFF, 2'b11, 1'b1, 32'h1234_5678);
        run_one("R3 wrap 32", 32'hA5A5_0F0F, 32'd32, 2'b00, 1'b0, 32'hA5A5_0F0F);
        run_one("R3 wrap 33", 32'h0000_00F0, 32'd33, 2'b01, 1'b0, 32'h0000_0078);
        run_one("R4 sat shl 32", 32'hFFFF_FFFF, 32'd32, 2'b00, 1'b1, 32'h0);
        run_one("R4 sat shr 33", 32'hFFFF_FFFF, 32'd33, 2'b01, 1'b1, 32'h0);
        run_one("R5 sat sar neg", 32'h8000_0001, 32'd33, 2'b10, 1'b1, 32'hFFFF_FFFF);
        run_one("R5 sat sar pos", 32'h7FFF_FFFF, 32'd32, 2'b10, 1'b1, 32'h0);
        run_one("R6 sat in range", 32'h0000_0F00, 32'd4, 2'b01, 1'b1, 32'h0000_00F0);
        run_one("R7 sat all ones", 32'h0000_0001, 32'hFFFF_FFFF, 2'b00, 1'b1, 32'h0);
        run_one("R7 sat 7fffffff", 32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 1'b1, 32'hFFFF_FFFF);
        run_one("R9 sar neg 4", 32'h8000_0000, 32'd4, 2'b10, 1'b0, 32'hF800_0000);
        run_one("R9 shr no sign", 32'h8000_0000, 32'd4, 2'b01, 1'b0, 32'h0800_0000);
    endtask

    task automatic t_hold();
        logic [31:0] kept;
        apply(32'h0000_0F0F, 32'd4, 2'b00, 1'b0);
        kept = out_result;
        check("R8 setup", kept, 32'h0000_F0F0);
        for (int i = 0; i < 3; i++) begin
            in_data = 32'hFFFF_0000 ^ i; in_count = 32'd7 + i; in_op = 2'b01; in_sat = 1'b1;
            @(negedge clk);
            check("R8 hold", out_result, kept);
        end
    endtask

    task automatic t_sweep();
        logic [31:0] counts [6] = '{32'd0, 32'd31, 32'd32, 32'd33,
                                    32'h7FFF_FFFF, 32'hFFFF_FFFF};
        logic [31:0] datas [2]  = '{32'h7000_00F5, 32'h8000_0001};
        for (int di = 0; di < 2; di++)
            for (int ci = 0; ci < 6; ci++)
                for (int op = 0; op < 4; op++)
                    for (int m = 0; m < 2; m++)
                        run_one(tag_of(counts[ci], 2'(op), 1'(m)), datas[di], counts[ci],
                                2'(op), 1'(m),
                                model(datas[di], counts[ci], 2'(op), 1'(m)));
    endtask

    task automatic t_pseudo_random();
        logic [31:0] lfsr = 32'hACE1_1234;
        logic [31:0] d;
        logic [31:0] c;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            c = (i % 3 == 0) ? {26'd0, lfsr[5:0]} : lfsr;
            run_one(tag_of(c, lfsr[9:8], lfsr[10]), d, c, lfsr[9:8], lfsr[10],
                    model(d, c, lfsr[9:8], lfsr[10]));
        end
    endtask

    initial begin
        t_reset();
        t_valid();
        t_directed();
        t_hold();
        t_sweep();
        t_pseudo_random();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule